// File: doc/BRIEF.md
# Byte-Wide Memory Port with Power-Fail Write Protect

This block is a clocked model of a byte-wide static memory that is driven through a classic active-low control set: chip enable, output enable and write enable. The address and data are plain inputs. The bidirectional data bus is split into a data-in input, a data-out output and a drive-enable output, so that a pad ring outside the block can form the real three-state bus. The array depth comes from the address width. The default build is small, and setting `ADDR_W` to 15 gives the full 32K-by-8 array. A timekeeper can place its register bank at the top addresses.

Every control input is sampled on the rising clock edge. The block decodes idle, read and write modes. It tracks a write window that opens when chip enable and write enable are both low and ends as soon as either of them returns high. The byte is committed into the array on the edge that ends the window. A digital power-fail input write-protects the whole array. Raising it at any point inside a window cancels that write.

Because this is a control-pin interface, there is no valid/ready handshake. The host keeps the address steady during a write window. The block adds no back-pressure, and every result appears one clock after the inputs that cause it.

Top module: `bytewide_mem_port`

## Requirements
- R1: The array holds 2^ADDR_W bytes of DATA_W bits (defaults 11 and 8; ADDR_W=15 gives 32,768 bytes). Each byte is selected by the full address with no aliasing.
- R2: On each rising edge, `dout` loads the byte stored at the sampled `addr`. A read result is therefore valid one clock after the address is presented.
- R3: `dout_oe` is 1 in the cycle after an edge that sampled `ce_n`=0, `oe_n`=0 and `we_n`=1. It is 0 after every other edge.
- R4: If `we_n` is sampled low, `dout_oe` is 0 in the following cycle, even when `ce_n` and `oe_n` are both low.
- R5: The write window opens at the first edge that samples both `ce_n` and `we_n` low, whichever of the two fell last. It closes at the first edge that samples either of them high. On that closing edge the array stores the `din` and `addr` sampled on the last edge of the window.
- R6: If `pwr_fail` is 1 on the closing edge of a window, no byte is written and the stored contents stay unchanged.
- R7: If `pwr_fail` is 1 on any edge inside a write window, that write is aborted, even if `pwr_fail` has dropped before the window closes.
- R8: A read that is sampled on the closing edge of a write, to the address being written, returns the new byte one clock later.
- R9: While `rst_n` is 0, `dout_oe` and `dout` are 0 and no write window is in progress.
- R10: A write controlled by chip enable works the same way: with `we_n` held low, `ce_n` falling opens the window and `ce_n` rising closes it and commits the byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| pwr_fail | input | 1 | Supply out of tolerance; blocks all writes while 1 |
| dout | output | DATA_W | Read data toward the bus |
| dout_oe | output | 1 | Bus drive enable for `dout` |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it. This covers the drive enable, the read byte and the commit on a window-closing edge. The bench therefore changes inputs on the falling edge and samples outputs 1 ns after the next rising edge. A bench model of the window and abort rules runs in step with each driven cycle and predicts the drive enable and the read byte for that single edge. Data checks are skipped only for addresses the bench has never written. Directed sequences cover the write controlled by write enable, the write controlled by chip enable, power-fail at the closing edge, power-fail in the middle of a window, and a read of the same address on the closing edge. Each is compared against constant expected bytes.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

  typedef enum logic [1:0] {
    PM_IDLE  = 2'd0,
    PM_READ  = 2'd1,
    PM_WRITE = 2'd2
  } port_mode_e;

  function automatic port_mode_e decode_mode(input logic ce_n, input logic we_n);
    if (ce_n)      return PM_IDLE;
    else if (we_n) return PM_READ;
    else           return PM_WRITE;
  endfunction

endpackage

// File: rtl/bmp_ctrl.sv
module bmp_ctrl
  import bmp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              pwr_fail,
  output port_mode_e        mode,
  output logic              commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic win_q;
  logic abort_q;
  logic win_now;

  assign mode    = decode_mode(ce_n, we_n);
  assign win_now = (mode == PM_WRITE);

  // The window ends on the first edge where either enable is back high.
  assign commit = win_q && !win_now && !abort_q && !pwr_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      abort_q <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      win_q <= win_now;
      if (win_now) begin
        wr_addr <= addr;
        wr_data <= din;
        // A fresh window clears the abort; power-fail inside it sets it.
        abort_q <= (win_q ? abort_q : 1'b0) | pwr_fail;
      end else begin
        abort_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bmp_array.sv
module bmp_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter bit WR_FWD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  generate
    if (WR_FWD) begin : g_fwd
      // Same-edge read of the address being committed sees the new byte.
      always_comb begin
        if (wr_en && (wr_addr == rd_addr)) rd_next = wr_data;
        else                               rd_next = mem[rd_addr];
      end
    end else begin : g_nofwd
      always_comb rd_next = mem[rd_addr];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_next;
  end

endmodule

// File: rtl/bmp_drive.sv
module bmp_drive
  import bmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  port_mode_e mode,
  input  logic       oe_n,
  output logic       drive
);

  always_ff @(posedge clk) begin
    if (!rst_n) drive <= 1'b0;
    else        drive <= (mode == PM_READ) && !oe_n;
  end

endmodule

// File: rtl/bytewide_mem_port.sv
module bytewide_mem_port
  import bmp_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              pwr_fail,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  port_mode_e        mode;
  logic              commit;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  bmp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .addr(addr),
    .din(din), .pwr_fail(pwr_fail), .mode(mode), .commit(commit),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  bmp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_FWD(1'b1)) u_array (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(addr), .rd_data(dout)
  );

  bmp_drive u_drive (
    .clk(clk), .rst_n(rst_n), .mode(mode), .oe_n(oe_n), .drive(dout_oe)
  );

endmodule

// File: rtl/bmp_chk.sv
module bmp_chk (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic we_n,
  input logic pwr_fail,
  input logic dout_oe,
  input logic commit
);

  // R3
  oe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!ce_n && !oe_n && we_n));

  // R4
  we_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> !dout_oe);

  // R5
  wr_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ((ce_n || we_n) && $past(!ce_n && !we_n)));

  // R7
  pf_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(pwr_fail && !ce_n && !we_n));

endmodule

bind bytewide_mem_port bmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .pwr_fail(pwr_fail), .dout_oe(dout_oe), .commit(commit)
);

// File: tb/tb_bytewide_mem_port.sv
module tb_bytewide_mem_port;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pwr_fail = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;
  int total = 0, bad = 0;

  // Bench model state
  logic [DW-1:0] m_mem [DEPTH];
  bit            m_vld [DEPTH];
  bit            m_win, m_abort;
  logic [AW-1:0] m_wa;
  logic [DW-1:0] m_wd;

  always #2 clk = ~clk;

  bytewide_mem_port #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .pwr_fail(pwr_fail), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic bit drive_expected(bit c, bit o, bit w);
    return !c && !o && w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive on the falling edge, predict, sample 1 ns after the rising edge.
  task automatic cyc(bit c, bit o, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                     bit pf, string tag);
    bit win_now, cm, ev;
    logic [DW-1:0] ed;
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w; addr = a; din = d; pwr_fail = pf;
    win_now = !c && !w;
    cm = m_win && !win_now && !m_abort && !pf;
    if (cm && (m_wa == a)) begin ed = m_wd; ev = 1'b1; end
    else begin ed = m_mem[a]; ev = m_vld[a]; end
    if (cm) begin m_mem[m_wa] = m_wd; m_vld[m_wa] = 1'b1; end
    if (win_now) begin
      m_abort = (m_win ? m_abort : 1'b0) | pf;
      m_wa = a; m_wd = d;
    end else m_abort = 1'b0;
    m_win = win_now;
    @(posedge clk); #1;
    check((!c && !o && !w) ? "R4 drive" : "R3 drive", {31'd0, dout_oe},
          {31'd0, drive_expected(c, o, w)});
    if (ev) check(tag, {24'd0, dout}, {24'd0, ed});
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
    m_win = 1'b0; m_abort = 1'b0; m_wa = '0; m_wd = '0;
    // R9: reset state with read-looking inputs applied
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 drive", {31'd0, dout_oe}, 32'd0);
    check("R9 data", {24'd0, dout}, 32'd0);
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;

    // R5: write-enable controlled write then read
    cyc(1'b0, 1'b1, 1'b0, 11'd5, 8'hA5, 1'b0, "R5");
    cyc(1'b0, 1'b1, 1'b1, 11'd5, 8'h00, 1'b0, "R8");
    cyc(1'b0, 1'b0, 1'b1, 11'd5, 8'h00, 1'b0, "R2");
    check("R5 value", {24'd0, dout}, 32'hA5);
    check("R3 on", {31'd0, dout_oe}, 32'd1);

    // R10: chip-enable controlled write
    cyc(1'b1, 1'b1, 1'b0, 11'd9, 8'h3C, 1'b0, "R10");
    cyc(1'b0, 1'b1, 1'b0, 11'd9, 8'h3C, 1'b0, "R10");
    cyc(1'b1, 1'b1, 1'b0, 11'd9, 8'h00, 1'b0, "R10");
    cyc(1'b0, 1'b0, 1'b1, 11'd9, 8'h00, 1'b0, "R10");
    check("R10 value", {24'd0, dout}, 32'h3C);

    // R6: power-fail on the closing edge
    cyc(1'b0, 1'b1, 1'b0, 11'd5, 8'h11, 1'b0, "R6");
    cyc(1'b0, 1'b1, 1'b1, 11'd5, 8'h00, 1'b1, "R6");
    cyc(1'b0, 1'b0, 1'b1, 11'd5, 8'h00, 1'b0, "R6");
    check("R6 kept", {24'd0, dout}, 32'hA5);

    // R7: power-fail only in the middle of the window
    cyc(1'b0, 1'b1, 1'b0, 11'd9, 8'h22, 1'b1, "R7");
    cyc(1'b0, 1'b1, 1'b0, 11'd9, 8'h22, 1'b0, "R7");
    cyc(1'b0, 1'b1, 1'b1, 11'd9, 8'h00, 1'b0, "R7");
    cyc(1'b0, 1'b0, 1'b1, 11'd9, 8'h00, 1'b0, "R7");
    check("R7 kept", {24'd0, dout}, 32'h3C);

    // R4 then R8: all enables low, then close and read the same byte at once
    cyc(1'b0, 1'b0, 1'b0, 11'd5, 8'h77, 1'b0, "R4");
    check("R4 off", {31'd0, dout_oe}, 32'd0);
    cyc(1'b0, 1'b0, 1'b1, 11'd5, 8'h00, 1'b0, "R8");
    check("R8 fwd", {24'd0, dout}, 32'h77);

    // R1: top and bottom addresses do not alias
    cyc(1'b0, 1'b1, 1'b0, 11'(DEPTH - 1), 8'hE1, 1'b0, "R1");
    cyc(1'b1, 1'b1, 1'b0, 11'(DEPTH - 1), 8'h00, 1'b0, "R1");
    cyc(1'b0, 1'b1, 1'b0, 11'd0, 8'h0E, 1'b0, "R1");
    cyc(1'b1, 1'b1, 1'b1, 11'd0, 8'h00, 1'b0, "R1");
    cyc(1'b0, 1'b0, 1'b1, 11'(DEPTH - 1), 8'h00, 1'b0, "R1");
    check("R1 top", {24'd0, dout}, 32'hE1);

    // Constrained random mix over a small address set
    for (int n = 0; n < 4000; n++) begin
      bit c, o, w, pf;
      logic [AW-1:0] a;
      c  = ($urandom_range(3) == 0);
      o  = ($urandom_range(2) == 0);
      w  = $urandom_range(1);
      pf = ($urandom_range(15) == 0);
      a  = ($urandom_range(4) == 0) ? 11'(DEPTH - 1 - $urandom_range(1))
                                    : 11'($urandom_range(7));
      cyc(c, o, w, a, 8'($urandom), pf, "R2 R5 R6 R7 R8 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule